// File: doc/BRIEF.md
# LPC Peripheral Cycle Responder

This block is the target side of a Low Pin Count bus for a peripheral that answers I/O and DMA cycles. It watches the framing strobe and the four-bit multiplexed bus, recognises a cycle from its opening nibble, and collects the header: a cycle-type nibble, then either a 16-bit I/O address or a DMA channel and size. On writes it also collects the data byte. After the host's two-clock turnaround, the block drives a fixed run of wait SYNC nibbles. The length of that run and the SYNC code both depend on the cycle class and direction. The block then drives a ready SYNC, returns the data byte on reads, and releases the bus through its own turnaround.

A simple local port carries each access to the back-end registers. It provides an address, write data, a one-clock read or write strobe and a DMA flag, and it returns read data with a ready level. On I/O cycles a slow back end can hold ready low. The block then keeps the cycle alive with repeated long-wait SYNC nibbles, up to a bounded count, and ends the cycle with an error SYNC if that count runs out. Pulling the framing strobe low at any time abandons the current cycle. Reset silences the bus side completely.

Top module: `lpc_cycle_responder`

## Requirements
- R1: A cycle starts only when LAD reads 0000 on the last clock that nLFRAME is low. Any other value on that clock leaves the block idle, with LAD released and no local strobe.
- R2: The cycle-type nibble is decoded as follows. Bits [3:2] = 00 selects I/O and 10 selects DMA. Bit 1 = 1 marks a write (data flows from the host to the block). Bit 0 must be 0. Any other type is ignored. An I/O cycle then carries four address nibbles, most significant first. A DMA cycle carries a channel nibble (channel in bits [2:0]) and a size nibble. A write then carries one data byte, low nibble first, followed by two host turnaround clocks.
- R3: An I/O read drives exactly three wait SYNC nibbles and an I/O write exactly two before the closing SYNC. Every I/O wait nibble is 0110.
- R4: A DMA read drives exactly three wait SYNC nibbles and a DMA write exactly four, each of them 0101. The local ready input has no effect on DMA cycles.
- R5: On an I/O cycle, if local ready is low once the fixed waits are done, the block drives one extra 0110 nibble per clock, up to 330 of them. If ready is high on any clock from the end of the fixed waits up to and including the clock after the 330th extra nibble, that clock carries the ready SYNC.
- R6: If local ready is still low on the clock after the 330th extra nibble, the block drives the error SYNC 1010 on that clock. It releases LAD on the next clock and returns to idle.
- R7: On the first host turnaround clock, the block raises either the local write strobe or the local read strobe, never both, for exactly one clock. At the same time it presents the address (the I/O address, or the DMA channel zero-extended), the write data and the DMA flag.
- R8: The ready SYNC is 0000. On a read, the local read data is captured on the ready-SYNC clock and driven on the next two clocks, low nibble first.
- R9: After the ready SYNC (and after the data nibbles on a read), the block drives 1111 for one clock and then releases LAD.
- R10: nLFRAME low on any clock aborts the cycle in progress. LAD is released from the following clock, and START detection restarts, so a 0000 on that clock opens a new cycle.
- R11: Reset is active low and asynchronous. While it is asserted, LAD is released, nLFRAME is ignored and nLDRQ is high. nLDRQ is never driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| lframe_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Multiplexed bus value as seen at the pins |
| lad_out | output | 4 | Nibble the block drives onto the bus |
| lad_oe | output | 1 | Output enable for lad_out |
| ldrq_n | output | 1 | DMA request line, held inactive high |
| loc_addr | output | 16 | Local access address (I/O address or DMA channel) |
| loc_wdata | output | 8 | Local write data |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_dma | output | 1 | The current local access belongs to a DMA cycle |
| loc_rdata | input | 8 | Local read data, sampled on the ready-SYNC clock |
| loc_ready | input | 1 | Local back end ready (I/O cycles only) |

## Verification
The bench builds the block with its default parameters: wait counts of 3 and 2 for I/O and 3 and 4 for DMA, wait codes 0110 and 0101, and a stretch limit of 330. Because the stretch limit is left at full size, the bench runs a stretched cycle all the way to the error SYNC and also releases ready on the very last clock the limit permits. These two runs pin down the exact bound. The 16-bit address width lets the vector table cover the all-zero and all-one addresses. The distinct wait codes let each cycle class be identified from the bus alone.

// File: rtl/lpc_resp_pkg.sv
package lpc_resp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTYPE,
      ST_ADDR,
      ST_CHAN,
      ST_SIZE,
      ST_WDATA,
      ST_HTAR,
      ST_SYNC,
      ST_RDATA,
      ST_PTAR
   } resp_state_e;

   typedef struct packed {
      logic is_dma;
      logic is_wr;
   } cyc_kind_t;

   localparam logic [3:0] START_NIB = 4'b0000;
   localparam logic [3:0] READY_NIB = 4'b0000;
   localparam logic [3:0] TAR_NIB   = 4'b1111;
   localparam logic [1:0] CT_IO     = 2'b00;
   localparam logic [1:0] CT_DMA    = 2'b10;
   localparam int         BYTE_W    = 8;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   // Accepted cycle types: I/O or DMA class, reserved bit 0 clear.
   function automatic logic ctype_known(input logic [3:0] ct);
      return ((ct[3:2] == CT_IO) || (ct[3:2] == CT_DMA)) && !ct[0];
   endfunction

endpackage

// File: rtl/lpc_wait_policy.sv
module lpc_wait_policy
   import lpc_resp_pkg::*;
#(
   parameter int         IO_RD_WAITS   = 3,
   parameter int         IO_WR_WAITS   = 2,
   parameter int         DMA_RD_WAITS  = 3,
   parameter int         DMA_WR_WAITS  = 4,
   parameter logic [3:0] IO_WAIT_CODE  = 4'b0110,
   parameter logic [3:0] DMA_WAIT_CODE = 4'b0101,
   parameter int         CW            = 3
) (
   input  cyc_kind_t       kind,
   output logic [CW-1:0]   nwait,
   output logic [3:0]      wcode
);

   localparam int MAXW = max_of4(IO_RD_WAITS, IO_WR_WAITS, DMA_RD_WAITS, DMA_WR_WAITS);

   if (IO_WAIT_CODE == READY_NIB || DMA_WAIT_CODE == READY_NIB) begin : g_bad_code
      $error("wait codes must differ from the ready SYNC");
   end
   if (MAXW >= (1 << CW)) begin : g_bad_width
      $error("wait counter width too small for the largest wait count");
   end
   if (IO_RD_WAITS < 0 || IO_WR_WAITS < 0 || DMA_RD_WAITS < 0 || DMA_WR_WAITS < 0) begin : g_bad_cnt
      $error("wait counts must not be negative");
   end

   assign wcode = kind.is_dma ? DMA_WAIT_CODE : IO_WAIT_CODE;

   if (IO_RD_WAITS == IO_WR_WAITS && DMA_RD_WAITS == DMA_WR_WAITS) begin : g_dir_blind
      // Direction does not matter: select on class alone.
      assign nwait = kind.is_dma ? CW'(DMA_RD_WAITS) : CW'(IO_RD_WAITS);
   end else begin : g_dir_aware
      always_comb begin
         unique case ({kind.is_dma, kind.is_wr})
            2'b00:   nwait = CW'(IO_RD_WAITS);
            2'b01:   nwait = CW'(IO_WR_WAITS);
            2'b10:   nwait = CW'(DMA_RD_WAITS);
            default: nwait = CW'(DMA_WR_WAITS);
         endcase
      end
   end

endmodule

// File: rtl/lpc_stretch_ctr.sv
module lpc_stretch_ctr #(
   parameter int LIMIT = 330,
   parameter int SW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [SW-1:0] cnt,
   output logic          at_limit
);

   if (LIMIT < 0) begin : g_bad_limit
      $error("stretch limit must not be negative");
   end

   if (LIMIT == 0) begin : g_no_stretch
      // No long waits allowed: a not-ready back end errors at once.
      assign cnt      = '0;
      assign at_limit = 1'b1;
   end else begin : g_counted
      if (LIMIT >= (1 << SW)) begin : g_bad_width
         $error("stretch counter width too small for the limit");
      end
      logic [SW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clr)
            cnt_q <= '0;
         else if (inc && cnt_q != SW'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
      end
      assign cnt      = cnt_q;
      assign at_limit = (cnt_q == SW'(LIMIT));
   end

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
   import lpc_resp_pkg::*;
(
   input  resp_state_e       st,
   input  logic              nib_odd,
   input  logic [3:0]        sync_code,
   input  logic [BYTE_W-1:0] rdata,
   output logic [3:0]        lad_out,
   output logic              lad_oe
);

   always_comb begin
      lad_out = TAR_NIB;
      lad_oe  = 1'b0;
      unique case (st)
         ST_SYNC: begin
            lad_out = sync_code;
            lad_oe  = 1'b1;
         end
         ST_RDATA: begin
            lad_out = nib_odd ? rdata[7:4] : rdata[3:0];
            lad_oe  = 1'b1;
         end
         ST_PTAR: begin
            lad_out = TAR_NIB;
            lad_oe  = !nib_odd;
         end
         default: begin
            lad_out = TAR_NIB;
            lad_oe  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lpc_cycle_responder.sv
module lpc_cycle_responder
   import lpc_resp_pkg::*;
#(
   parameter int         IO_RD_WAITS   = 3,
   parameter int         IO_WR_WAITS   = 2,
   parameter int         DMA_RD_WAITS  = 3,
   parameter int         DMA_WR_WAITS  = 4,
   parameter logic [3:0] IO_WAIT_CODE  = 4'b0110,
   parameter logic [3:0] DMA_WAIT_CODE = 4'b0101,
   parameter logic [3:0] ERR_CODE      = 4'b1010,
   parameter int         STRETCH_MAX   = 330,
   parameter int         ADDR_NIBS     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lframe_n,
   input  logic [3:0]             lad_in,
   output logic [3:0]             lad_out,
   output logic                   lad_oe,
   output logic                   ldrq_n,
   output logic [4*ADDR_NIBS-1:0] loc_addr,
   output logic [BYTE_W-1:0]      loc_wdata,
   output logic                   loc_wr,
   output logic                   loc_rd,
   output logic                   loc_dma,
   input  logic [BYTE_W-1:0]      loc_rdata,
   input  logic                   loc_ready
);

   localparam int ADDR_W = 4 * ADDR_NIBS;
   localparam int NCW    = $clog2(ADDR_NIBS);
   localparam int MAXW   = max_of4(IO_RD_WAITS, IO_WR_WAITS, DMA_RD_WAITS, DMA_WR_WAITS);
   localparam int CW     = (MAXW > 0) ? $clog2(MAXW + 1) : 1;
   localparam int SW     = (STRETCH_MAX > 0) ? $clog2(STRETCH_MAX + 1) : 1;

   if (ADDR_NIBS < 2) begin : g_bad_addr
      $error("address must span at least two nibbles");
   end
   if (ERR_CODE == READY_NIB || ERR_CODE == IO_WAIT_CODE || ERR_CODE == DMA_WAIT_CODE) begin : g_bad_err
      $error("error SYNC must differ from ready and wait codes");
   end

   resp_state_e         st;
   cyc_kind_t           kind;
   logic [NCW-1:0]      nib;
   logic [ADDR_W-1:0]   addr_q;
   logic [BYTE_W-1:0]   wdata_q;
   logic [BYTE_W-1:0]   rdata_q;
   logic [CW-1:0]       wcnt;
   logic [CW-1:0]       nwait;
   logic [3:0]          wcode;
   logic [3:0]          sync_code;
   logic [SW-1:0]       str_cnt;
   logic                at_limit;
   logic                sync_phase;
   logic                fixed_wait;
   logic                ready_eff;
   logic                stretch_inc;
   logic                nib_odd;

   lpc_wait_policy #(
      .IO_RD_WAITS   (IO_RD_WAITS),
      .IO_WR_WAITS   (IO_WR_WAITS),
      .DMA_RD_WAITS  (DMA_RD_WAITS),
      .DMA_WR_WAITS  (DMA_WR_WAITS),
      .IO_WAIT_CODE  (IO_WAIT_CODE),
      .DMA_WAIT_CODE (DMA_WAIT_CODE),
      .CW            (CW)
   ) u_policy (
      .kind  (kind),
      .nwait (nwait),
      .wcode (wcode)
   );

   assign sync_phase  = (st == ST_SYNC);
   assign fixed_wait  = (wcnt < nwait);
   assign ready_eff   = kind.is_dma | loc_ready;
   assign stretch_inc = sync_phase && lframe_n && !fixed_wait && !ready_eff && !at_limit;

   lpc_stretch_ctr #(
      .LIMIT (STRETCH_MAX),
      .SW    (SW)
   ) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!sync_phase),
      .inc      (stretch_inc),
      .cnt      (str_cnt),
      .at_limit (at_limit)
   );

   // SYNC nibble: fixed waits, then ready, long wait or error.
   always_comb begin
      if (fixed_wait)
         sync_code = wcode;
      else if (ready_eff)
         sync_code = READY_NIB;
      else if (!at_limit)
         sync_code = wcode;
      else
         sync_code = ERR_CODE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         kind    <= '0;
         nib     <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         wcnt    <= '0;
      end else if (!lframe_n) begin
         // Framing strobe low: abort and re-arm START detection.
         st  <= (lad_in == START_NIB) ? ST_CTYPE : ST_IDLE;
         nib <= '0;
      end else begin
         unique case (st)
            ST_IDLE: st <= ST_IDLE;
            ST_CTYPE: begin
               if (ctype_known(lad_in)) begin
                  kind.is_dma <= lad_in[3];
                  kind.is_wr  <= lad_in[1];
                  st          <= lad_in[3] ? ST_CHAN : ST_ADDR;
                  addr_q      <= '0;
                  nib         <= '0;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_ADDR: begin
               addr_q <= {addr_q[ADDR_W-5:0], lad_in};
               if (nib == NCW'(ADDR_NIBS - 1)) begin
                  nib <= '0;
                  st  <= kind.is_wr ? ST_WDATA : ST_HTAR;
               end else begin
                  nib <= nib + 1'b1;
               end
            end
            ST_CHAN: begin
               addr_q <= ADDR_W'(lad_in[2:0]);
               st     <= ST_SIZE;
            end
            ST_SIZE: begin
               nib <= '0;
               st  <= kind.is_wr ? ST_WDATA : ST_HTAR;
            end
            ST_WDATA: begin
               if (nib_odd) begin
                  wdata_q[7:4] <= lad_in;
                  nib          <= '0;
                  st           <= ST_HTAR;
               end else begin
                  wdata_q[3:0] <= lad_in;
                  nib          <= nib + 1'b1;
               end
            end
            ST_HTAR: begin
               if (nib_odd) begin
                  nib  <= '0;
                  wcnt <= '0;
                  st   <= ST_SYNC;
               end else begin
                  nib <= nib + 1'b1;
               end
            end
            ST_SYNC: begin
               if (fixed_wait) begin
                  wcnt <= wcnt + 1'b1;
               end else if (ready_eff) begin
                  rdata_q <= loc_rdata;
                  nib     <= '0;
                  st      <= kind.is_wr ? ST_PTAR : ST_RDATA;
               end else if (at_limit) begin
                  st <= ST_IDLE;
               end
            end
            ST_RDATA: begin
               if (nib_odd) begin
                  nib <= '0;
                  st  <= ST_PTAR;
               end else begin
                  nib <= nib + 1'b1;
               end
            end
            ST_PTAR: begin
               if (nib_odd) begin
                  nib <= '0;
                  st  <= ST_IDLE;
               end else begin
                  nib <= nib + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign nib_odd = nib[0];

   lpc_lad_drive u_drive (
      .st        (st),
      .nib_odd   (nib_odd),
      .sync_code (sync_code),
      .rdata     (rdata_q),
      .lad_out   (lad_out),
      .lad_oe    (lad_oe)
   );

   // Local access: one strobe on the first host turnaround clock.
   assign loc_addr  = addr_q;
   assign loc_wdata = wdata_q;
   assign loc_dma   = kind.is_dma;
   assign loc_wr    = (st == ST_HTAR) && !nib_odd && kind.is_wr;
   assign loc_rd    = (st == ST_HTAR) && !nib_odd && !kind.is_wr;

   // No DMA requests are raised by this block.
   assign ldrq_n = 1'b1;

endmodule

// File: rtl/lpc_cycle_responder_chk.sv
module lpc_cycle_responder_chk #(
   parameter int         STRETCH_MAX = 330,
   parameter int         SW          = 9,
   parameter logic [3:0] ERR_CODE    = 4'b1010
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lframe_n,
   input logic [3:0]    lad_out,
   input logic          lad_oe,
   input logic          ldrq_n,
   input logic          loc_wr,
   input logic          loc_rd,
   input logic          loc_dma,
   input logic          loc_ready,
   input logic          sync_phase,
   input logic [SW-1:0] str_cnt
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R11: assert (!lad_oe && ldrq_n)
            else $error("bus driven or request active during reset");
      end
   end

   assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lframe_n |=> !lad_oe)
      else $error("LAD still driven after framing strobe");

   assert_error_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_phase && lad_oe && lad_out == ERR_CODE) |=> !lad_oe)
      else $error("bus not released after error SYNC");

   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_rd, loc_wr}))
      else $error("read and write strobes together");

   assert_stretch_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(str_cnt) <= STRETCH_MAX)
      else $error("stretch count beyond limit");

   assert_ready_needs_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_phase && lad_out == 4'b0000) |-> (loc_ready || loc_dma))
      else $error("ready SYNC on I/O cycle without local ready");

endmodule

bind lpc_cycle_responder lpc_cycle_responder_chk #(
   .STRETCH_MAX (STRETCH_MAX),
   .SW          (SW),
   .ERR_CODE    (ERR_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lframe_n   (lframe_n),
   .lad_out    (lad_out),
   .lad_oe     (lad_oe),
   .ldrq_n     (ldrq_n),
   .loc_wr     (loc_wr),
   .loc_rd     (loc_rd),
   .loc_dma    (loc_dma),
   .loc_ready  (loc_ready),
   .sync_phase (sync_phase),
   .str_cnt    (str_cnt)
);

// File: tb/sim_lpc_cycle_responder.sv
`timescale 1ns/1ps
module sim_lpc_cycle_responder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lframe_n;
   logic [3:0]  lad_in;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic        ldrq_n;
   logic [15:0] loc_addr;
   logic [7:0]  loc_wdata;
   logic        loc_wr;
   logic        loc_rd;
   logic        loc_dma;
   logic [7:0]  loc_rdata;
   logic        loc_ready;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   lpc_cycle_responder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lframe_n  (lframe_n),
      .lad_in    (lad_in),
      .lad_out   (lad_out),
      .lad_oe    (lad_oe),
      .ldrq_n    (ldrq_n),
      .loc_addr  (loc_addr),
      .loc_wdata (loc_wdata),
      .loc_wr    (loc_wr),
      .loc_rd    (loc_rd),
      .loc_dma   (loc_dma),
      .loc_rdata (loc_rdata),
      .loc_ready (loc_ready)
   );

   // Row: ctype[43:40] addr[39:24] wdata[23:16] rdata[15:8] waits[7:4] wait_code[3:0]
   localparam logic [43:0] VECS [0:5] = '{
      {4'h0, 16'h0000, 8'h00, 8'h96, 4'd3, 4'h6},
      {4'h2, 16'h03F8, 8'hA5, 8'h00, 4'd2, 4'h6},
      {4'h0, 16'hFFFF, 8'h00, 8'h3C, 4'd3, 4'h6},
      {4'h8, 16'h0002, 8'h00, 8'hC3, 4'd3, 4'h5},
      {4'hA, 16'h0005, 8'h5A, 8'h00, 4'd4, 4'h5},
      {4'h2, 16'h1234, 8'h0F, 8'h00, 4'd2, 4'h6}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drv(input logic lf, input logic [3:0] v);
      @(negedge clk);
      lframe_n = lf;
      lad_in   = v;
   endtask

   task automatic send_header(input logic [3:0] ct, input logic [15:0] addr,
                              input logic [7:0] wd, input bit skip_start);
      if (!skip_start) drv(1'b0, 4'h0);
      drv(1'b1, ct);
      if (ct[3]) begin
         drv(1'b1, {1'b0, addr[2:0]});
         drv(1'b1, 4'h0);
      end else begin
         for (int i = 3; i >= 0; i--) drv(1'b1, addr[4*i +: 4]);
      end
      if (ct[1]) begin
         drv(1'b1, wd[3:0]);
         drv(1'b1, wd[7:4]);
      end
   endtask

   task automatic expect_quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         drv(1'b1, 4'hF);
         #1;
         check(!lad_oe && !loc_rd && !loc_wr, req, "bus and strobes quiet",
               {lad_oe, loc_rd, loc_wr}, 0);
      end
   endtask

   task automatic run_cycle(input logic [3:0] ct, input logic [15:0] addr,
                            input logic [7:0] wd, input logic [7:0] rd,
                            input int exp_waits, input logic [3:0] wcode,
                            input logic [3:0] exp_end, input int release_at,
                            input bit skip_start, input string req);
      bit wr  = ct[1];
      bit dma = ct[3];
      int waits = 0;
      logic [3:0] code;
      logic [15:0] exp_addr;
      exp_addr  = dma ? {13'b0, addr[2:0]} : addr;
      loc_rdata = rd;
      send_header(ct, addr, wd, skip_start);
      drv(1'b1, 4'hF);
      #1;
      check(loc_wr == wr && loc_rd == !wr, "R7", "local strobe", {loc_wr, loc_rd}, {wr, !wr});
      check(loc_dma == dma, "R7", "local DMA flag", loc_dma, dma);
      check(loc_addr == exp_addr, "R2", "local address", loc_addr, exp_addr);
      if (wr) check(loc_wdata == wd, "R2", "local write data", loc_wdata, wd);
      drv(1'b1, 4'hF);
      #1;
      check(!loc_wr && !loc_rd, "R7", "strobe lasts one clock", {loc_wr, loc_rd}, 0);
      forever begin
         @(negedge clk);
         if (release_at >= 0 && waits == release_at) loc_ready = 1'b1;
         #1;
         code = lad_out;
         if (!lad_oe || code != wcode || waits > 2000) break;
         waits++;
      end
      check(waits == exp_waits, req, "wait SYNC count", waits, exp_waits);
      check(lad_oe && code == exp_end, (exp_end == 4'h0) ? "R8" : "R6",
            "closing SYNC", {lad_oe, code}, {1'b1, exp_end});
      if (exp_end == 4'h0) begin
         if (!wr) begin
            @(negedge clk); #1;
            check(lad_oe && lad_out == rd[3:0], "R8", "read data low nibble", lad_out, rd[3:0]);
            @(negedge clk); #1;
            check(lad_oe && lad_out == rd[7:4], "R8", "read data high nibble", lad_out, rd[7:4]);
         end
         @(negedge clk); #1;
         check(lad_oe && lad_out == 4'hF, "R9", "turnaround drive", {lad_oe, lad_out}, 5'h1F);
         @(negedge clk); #1;
         check(!lad_oe, "R9", "turnaround release", lad_oe, 0);
      end else begin
         @(negedge clk); #1;
         check(!lad_oe, "R6", "release after error", lad_oe, 0);
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      lframe_n  = 1'b0;
      lad_in    = 4'h0;
      loc_rdata = 8'h00;
      loc_ready = 1'b1;

      // R11: reset ignores the framing strobe and keeps the bus silent
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         check(!lad_oe && ldrq_n, "R11", "reset state", {lad_oe, ldrq_n}, 1);
      end
      @(negedge clk);
      rst_n    = 1'b1;
      lframe_n = 1'b1;
      lad_in   = 4'hF;
      expect_quiet(3, "R11");

      // Table of I/O and DMA cycles (R2 R3 R4 R7 R8 R9)
      for (int i = 0; i < 6; i++) begin
         run_cycle(VECS[i][43:40], VECS[i][39:24], VECS[i][23:16], VECS[i][15:8],
                   int'(VECS[i][7:4]), VECS[i][3:0], 4'h0, -1, 1'b0,
                   VECS[i][43] ? "R4" : "R3");
         drv(1'b1, 4'hF);
      end

      // R1: non-zero START is ignored
      drv(1'b0, 4'h5);
      send_header(4'h2, 16'h0080, 8'h11, 1'b1);
      expect_quiet(8, "R1");
      // R1: multi-clock frame, the last nibble (0000) counts
      drv(1'b0, 4'h3);
      run_cycle(4'h0, 16'h0060, 8'h00, 8'h4B, 3, 4'h6, 4'h0, -1, 1'b0, "R1");

      // R2: memory cycle type is not answered
      drv(1'b0, 4'h0);
      drv(1'b1, 4'h4);
      expect_quiet(10, "R2");

      // R5: stretch by ten long waits
      loc_ready = 1'b0;
      run_cycle(4'h0, 16'h0378, 8'h00, 8'hE1, 13, 4'h6, 4'h0, 13, 1'b0, "R5");
      drv(1'b1, 4'hF);
      // R5: ready on the last permitted clock still wins
      loc_ready = 1'b0;
      run_cycle(4'h2, 16'h0379, 8'h77, 8'h00, 332, 4'h6, 4'h0, 332, 1'b0, "R5");
      drv(1'b1, 4'hF);
      // R6: never ready -> error SYNC after the 330 extra nibbles
      loc_ready = 1'b0;
      run_cycle(4'h0, 16'h037A, 8'h00, 8'h00, 333, 4'h6, 4'hA, -1, 1'b0, "R6");
      expect_quiet(2, "R6");

      // R4: DMA cycles ignore local ready
      loc_ready = 1'b0;
      run_cycle(4'hA, 16'h0001, 8'h3E, 8'h00, 4, 4'h5, 4'h0, -1, 1'b0, "R4");
      loc_ready = 1'b1;
      drv(1'b1, 4'hF);

      // R10: abort in the address phase
      drv(1'b0, 4'h0);
      drv(1'b1, 4'h0);
      drv(1'b1, 4'h1);
      drv(1'b0, 4'h7);
      expect_quiet(10, "R10");

      // R10: abort during stretched SYNC, new cycle starts at once
      loc_ready = 1'b0;
      send_header(4'h0, 16'h02F8, 8'h00, 1'b0);
      drv(1'b1, 4'hF);
      drv(1'b1, 4'hF);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); #1;
         check(lad_oe && lad_out == 4'h6, "R5", "long wait while not ready", {lad_oe, lad_out}, 5'h16);
      end
      drv(1'b0, 4'h0);
      @(posedge clk); #1;
      check(!lad_oe, "R10", "release after abort", lad_oe, 0);
      loc_ready = 1'b1;
      run_cycle(4'h0, 16'h02F9, 8'h00, 8'h5D, 3, 4'h6, 4'h0, -1, 1'b1, "R10");
      drv(1'b1, 4'hF);

      // R11: asynchronous reset in the middle of a cycle
      loc_ready = 1'b0;
      send_header(4'h0, 16'h0100, 8'h00, 1'b0);
      drv(1'b1, 4'hF);
      drv(1'b1, 4'hF);
      @(negedge clk); #1;
      check(lad_oe, "R3", "driving before reset", lad_oe, 1);
      #1 rst_n = 1'b0;
      #1;
      check(!lad_oe && ldrq_n, "R11", "immediate release on reset", {lad_oe, ldrq_n}, 1);
      @(negedge clk);
      rst_n     = 1'b1;
      loc_ready = 1'b1;
      expect_quiet(2, "R11");
      run_cycle(4'h2, 16'h0101, 8'hC9, 8'h00, 2, 4'h6, 4'h0, -1, 1'b0, "R3");
      check(ldrq_n, "R11", "request line stays high", ldrq_n, 1);

      done = 1;
      summary();
      $finish;
   end

endmodule